// File: doc/BRIEF.md
# Quadword Access Splitter

This block turns one 16-byte load or store into two 8-byte accesses on a 64-bit data memory port, and moves the data between memory and an even/odd register pair. Issue hands it an effective address, the endian mode, a preferred-encoding flag, the target/source, base and index register numbers and, for stores, both doublewords of the pair. The block then asks issue to stall, performs the lower-address doubleword first and the higher one second, and finishes with either a single pair write-back or a single exception report.

Before any memory access is made, the block checks two things. It rejects illegal operand combinations with the illegal-instruction vector and the illegal cause bit set in the saved status. It also decides whether an unaligned access must fault for alignment, which depends on the endian mode and on whether the encoding is the preferred one. A memory error on either half ends the operation without any register write, and a failed first store half stops the second half from being issued.

Top module: `quad_access_splitter`

## Requirements
- R1: After reset, `busy`, `memReqValid`, `wbValid`, `excValid` and `opDone` are all low.
- R2: A legal operation issues exactly two accesses in order, first at address A and then at A+8. Each access is held, with a stable address, until `memAck`. The second access starts only after the first has been acknowledged without error.
- R3: `busy` is high from the cycle after acceptance through the cycle with `opDone`, and low afterwards. A `reqValid` presented while `busy` is high is ignored.
- R4: Big-endian load: the even register receives the doubleword read at A, and the odd register receives the doubleword read at A+8.
- R5: Little-endian load: the even register receives the doubleword read at A+8, and the odd register receives the doubleword read at A.
- R6: Stores follow the same ordering as loads. In big-endian mode, A receives the even-register data and A+8 the odd-register data. In little-endian mode this is swapped.
- R7: A load whose target equals its base raises `excVector`=0x700 with `excSavedStatus` bit 19 (mask 0x80000) set, makes no memory access and does no write-back. A store whose source equals its base is legal.
- R8: A load-and-reserve (`reqIsReserve`=1) is also illegal when its target equals its index register. A plain load whose target equals its index is legal.
- R9: A little-endian, non-preferred load with A[3:0]≠0 raises `excVector`=0x600 with `excDataAddr`=A and bit 19 clear. It makes no memory access and does no write-back.
- R10: A big-endian load with A[3:0]≠0 completes normally in both the preferred and the non-preferred form.
- R11: Stores never raise an alignment fault. A store at A = 16n+1 completes in both endian modes, with its two accesses at A and A+8.
- R12: A little-endian, preferred, unaligned load completes when `LE_PREF_FAULT`=0 and raises 0x600 when `LE_PREF_FAULT`=1.
- R13: A memory error on either half raises `excVector`=0x300 with `excDataAddr` equal to the failing access address, and does no write-back. A store whose first half fails issues no second half.
- R14: The write-back pair is `wbRegLo` = target with bit 0 cleared and `wbRegHi` = target with bit 0 set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reqValid | input | 1 | Operation offered; accepted when `busy` is low |
| reqIsStore | input | 1 | 1 = store, 0 = load |
| reqIsReserve | input | 1 | Load-and-reserve variant |
| reqPreferred | input | 1 | Instruction is in its preferred encoding |
| reqLittle | input | 1 | Little-endian mode |
| reqAddr | input | ADDR_W | Effective address A |
| reqTgt | input | REG_W | Target (load) or source (store) register |
| reqBase | input | REG_W | Base register number |
| reqIndex | input | REG_W | Index register number |
| reqStLo | input | DATA_W | Store data of the even register |
| reqStHi | input | DATA_W | Store data of the odd register |
| busy | output | 1 | Stall toward issue |
| memReqValid | output | 1 | Memory access request |
| memReqWrite | output | 1 | Access is a write |
| memReqAddr | output | ADDR_W | Access address |
| memReqWData | output | DATA_W | Write data |
| memAck | input | 1 | Access complete this cycle |
| memErr | input | 1 | Access failed (qualified by `memAck`) |
| memRdData | input | DATA_W | Read data (qualified by `memAck`) |
| wbValid | output | 1 | Register-pair write strobe |
| wbRegLo | output | REG_W | Even register number |
| wbDataLo | output | DATA_W | Even register data |
| wbRegHi | output | REG_W | Odd register number |
| wbDataHi | output | DATA_W | Odd register data |
| opDone | output | 1 | Operation finished (completion or exception) |
| excValid | output | 1 | Exception reported |
| excVector | output | 12 | Exception vector |
| excDataAddr | output | ADDR_W | Faulting data address |
| excSavedStatus | output | 32 | Saved status bits; bit 19 = illegal form |

## Verification
If a sequencing state goes wrong, it shows at the memory port within one access: the address drifts while the request waits, a second half is issued without an acknowledged first one, or requests overlap with `busy` low. If a wrong pair-ordering or endian flag is captured, it shows only at the final write-back or in the write data of a store, so the directed tests use different read patterns per address in both endian modes. A wrong fault decision shows in the cycle after acceptance as a bad vector, or as memory traffic where none should occur. For that reason each fault case also counts the accesses made.

// File: rtl/qas_pkg.sv
package qas_pkg;

  typedef enum logic [2:0] {
    ST_IDLE = 3'd0,
    ST_LO   = 3'd1,
    ST_HI   = 3'd2,
    ST_DONE = 3'd3,
    ST_EXC  = 3'd4
  } seqState_t;

  typedef enum logic [1:0] {
    EXC_NONE,
    EXC_ILLEGAL,
    EXC_ALIGN,
    EXC_MEM
  } excKind_t;

  // strobes from the sequencer to the datapath
  typedef struct packed {
    logic capture;     // latch the request fields
    logic takeLo;      // latch read data of the first (lower address) half
    logic takeHi;      // latch read data of the second half
    logic driveHi;     // present the second-half address / data
    logic faultLatch;  // record the current access address as fault address
  } dpStrobe_t;

  localparam logic [11:0] VEC_ILLEGAL  = 12'h700;
  localparam logic [11:0] VEC_ALIGN    = 12'h600;
  localparam logic [11:0] VEC_MEMFAULT = 12'h300;

  localparam int unsigned CAUSE_ILLEGAL_BIT = 19;
  localparam int unsigned HALF_BYTES        = 8;
  localparam int unsigned QUAD_ALIGN_BITS   = 4;

endpackage

// File: rtl/qas_datapath.sv
module qas_datapath
  import qas_pkg::*;
#(
  parameter int unsigned ADDR_W        = 32,
  parameter int unsigned DATA_W        = 64,
  parameter int unsigned REG_W         = 5,
  parameter bit          LE_PREF_FAULT = 1'b0
) (
  input  logic              clk,
  input  logic              rst_n,
  input  dpStrobe_t         strobe,
  input  logic              reqIsStore,
  input  logic              reqIsReserve,
  input  logic              reqPreferred,
  input  logic              reqLittle,
  input  logic [ADDR_W-1:0] reqAddr,
  input  logic [REG_W-1:0]  reqTgt,
  input  logic [REG_W-1:0]  reqBase,
  input  logic [REG_W-1:0]  reqIndex,
  input  logic [DATA_W-1:0] reqStLo,
  input  logic [DATA_W-1:0] reqStHi,
  input  logic [DATA_W-1:0] memRdData,
  output logic              illegalHit,
  output logic              alignHit,
  output logic [ADDR_W-1:0] memReqAddr,
  output logic [DATA_W-1:0] memReqWData,
  output logic [REG_W-1:0]  wbRegLo,
  output logic [REG_W-1:0]  wbRegHi,
  output logic [DATA_W-1:0] wbDataLo,
  output logic [DATA_W-1:0] wbDataHi,
  output logic [ADDR_W-1:0] faultAddr
);

  localparam logic [ADDR_W-1:0] HALF_STEP = ADDR_W'(HALF_BYTES);

  logic [ADDR_W-1:0] opAddr;
  logic              opLittle;
  logic [REG_W-1:0]  opTgt;
  logic [DATA_W-1:0] stLo, stHi;
  logic [DATA_W-1:0] rdFirst, rdSecond;
  logic              firstOk;

  logic offQuad, tgtIsBase, tgtIsIndex, leUnalignedFault;

  // operand legality and alignment policy, judged on the offered request
  assign offQuad    = |reqAddr[QUAD_ALIGN_BITS-1:0];
  assign tgtIsBase  = (reqTgt == reqBase);
  assign tgtIsIndex = (reqTgt == reqIndex);
  assign illegalHit = !reqIsStore && (tgtIsBase || (reqIsReserve && tgtIsIndex));

  generate
    if (LE_PREF_FAULT) begin : g_pref_faults
      logic unusedPref;
      assign unusedPref       = reqPreferred;
      assign leUnalignedFault = offQuad;
    end else begin : g_pref_completes
      assign leUnalignedFault = offQuad && !reqPreferred;
    end
  endgenerate

  assign alignHit = !reqIsStore && reqLittle && leUnalignedFault;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      opAddr    <= '0;
      opLittle  <= 1'b0;
      opTgt     <= '0;
      stLo      <= '0;
      stHi      <= '0;
      rdFirst   <= '0;
      rdSecond  <= '0;
      firstOk   <= 1'b0;
      faultAddr <= '0;
    end else begin
      if (strobe.capture) begin
        opAddr    <= reqAddr;
        opLittle  <= reqLittle;
        opTgt     <= reqTgt;
        stLo      <= reqStLo;
        stHi      <= reqStHi;
        firstOk   <= 1'b0;
        faultAddr <= reqAddr;
      end
      if (strobe.takeLo) begin
        rdFirst <= memRdData;
        firstOk <= 1'b1;
      end
      if (strobe.takeHi) begin
        rdSecond <= memRdData;
      end
      if (strobe.faultLatch) begin
        faultAddr <= memReqAddr;
      end
    end
  end

  // memory side: lower address first; store data swaps with endian mode
  assign memReqAddr  = strobe.driveHi ? (opAddr + HALF_STEP) : opAddr;
  assign memReqWData = (strobe.driveHi ^ opLittle) ? stHi : stLo;

  // register side: even/odd pair, ordering swaps with endian mode
  assign wbRegLo  = {opTgt[REG_W-1:1], 1'b0};
  assign wbRegHi  = {opTgt[REG_W-1:1], 1'b1};
  assign wbDataLo = opLittle ? rdSecond : rdFirst;
  assign wbDataHi = opLittle ? rdFirst  : rdSecond;

  AST_HI_AFTER_LO: assert property (@(posedge clk) disable iff (!rst_n)
    strobe.driveHi |-> firstOk) else $error("second half without first"); // R2

endmodule

// File: rtl/qas_ctrl.sv
module qas_ctrl
  import qas_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        reqValid,
  input  logic        reqIsStore,
  input  logic        illegalHit,
  input  logic        alignHit,
  input  logic        memAck,
  input  logic        memErr,
  output dpStrobe_t   strobe,
  output logic        busy,
  output logic        memReqValid,
  output logic        memReqWrite,
  output logic        wbValid,
  output logic        opDone,
  output logic        excValid,
  output logic [11:0] excVector,
  output logic [31:0] excSavedStatus
);

  seqState_t state, nextState;
  excKind_t  kind, nextKind;
  logic      opStore;

  always_comb begin
    strobe    = '0;
    nextState = state;
    nextKind  = kind;
    unique case (state)
      ST_IDLE: begin
        if (reqValid) begin
          strobe.capture = 1'b1;
          if (illegalHit) begin
            nextState = ST_EXC;
            nextKind  = EXC_ILLEGAL;
          end else if (alignHit) begin
            nextState = ST_EXC;
            nextKind  = EXC_ALIGN;
          end else begin
            nextState = ST_LO;
            nextKind  = EXC_NONE;
          end
        end
      end
      ST_LO: begin
        if (memAck) begin
          if (memErr) begin
            strobe.faultLatch = 1'b1;
            nextState         = ST_EXC;
            nextKind          = EXC_MEM;
          end else begin
            strobe.takeLo = 1'b1;
            nextState     = ST_HI;
          end
        end
      end
      ST_HI: begin
        strobe.driveHi = 1'b1;
        if (memAck) begin
          if (memErr) begin
            strobe.faultLatch = 1'b1;
            nextState         = ST_EXC;
            nextKind          = EXC_MEM;
          end else begin
            strobe.takeHi = 1'b1;
            nextState     = ST_DONE;
          end
        end
      end
      ST_DONE: nextState = ST_IDLE;
      ST_EXC:  nextState = ST_IDLE;
      default: nextState = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state   <= ST_IDLE;
      kind    <= EXC_NONE;
      opStore <= 1'b0;
    end else begin
      state <= nextState;
      kind  <= nextKind;
      if (strobe.capture) opStore <= reqIsStore;
    end
  end

  assign busy        = (state != ST_IDLE);
  assign memReqValid = (state == ST_LO) || (state == ST_HI);
  assign memReqWrite = memReqValid && opStore;
  assign wbValid     = (state == ST_DONE) && !opStore;
  assign opDone      = (state == ST_DONE) || (state == ST_EXC);
  assign excValid    = (state == ST_EXC);

  always_comb begin
    unique case (kind)
      EXC_ILLEGAL: excVector = VEC_ILLEGAL;
      EXC_ALIGN:   excVector = VEC_ALIGN;
      EXC_MEM:     excVector = VEC_MEMFAULT;
      default:     excVector = 12'h000;
    endcase
  end

  assign excSavedStatus = (excValid && kind == EXC_ILLEGAL) ?
                          (32'd1 << CAUSE_ILLEGAL_BIT) : 32'd0;

  AST_REQ_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    memReqValid && !memAck |=> memReqValid) else $error("request dropped"); // R2
  AST_IDLE_AFTER_DONE: assert property (@(posedge clk) disable iff (!rst_n)
    opDone |=> !busy) else $error("busy after done"); // R3

endmodule

// File: rtl/quad_access_splitter.sv
module quad_access_splitter
  import qas_pkg::*;
#(
  parameter int unsigned ADDR_W        = 32,
  parameter int unsigned DATA_W        = 64,
  parameter int unsigned REG_W         = 5,
  parameter bit          LE_PREF_FAULT = 1'b0
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reqValid,
  input  logic              reqIsStore,
  input  logic              reqIsReserve,
  input  logic              reqPreferred,
  input  logic              reqLittle,
  input  logic [ADDR_W-1:0] reqAddr,
  input  logic [REG_W-1:0]  reqTgt,
  input  logic [REG_W-1:0]  reqBase,
  input  logic [REG_W-1:0]  reqIndex,
  input  logic [DATA_W-1:0] reqStLo,
  input  logic [DATA_W-1:0] reqStHi,
  output logic              busy,
  output logic              memReqValid,
  output logic              memReqWrite,
  output logic [ADDR_W-1:0] memReqAddr,
  output logic [DATA_W-1:0] memReqWData,
  input  logic              memAck,
  input  logic              memErr,
  input  logic [DATA_W-1:0] memRdData,
  output logic              wbValid,
  output logic [REG_W-1:0]  wbRegLo,
  output logic [DATA_W-1:0] wbDataLo,
  output logic [REG_W-1:0]  wbRegHi,
  output logic [DATA_W-1:0] wbDataHi,
  output logic              opDone,
  output logic              excValid,
  output logic [11:0]       excVector,
  output logic [ADDR_W-1:0] excDataAddr,
  output logic [31:0]       excSavedStatus
);

  dpStrobe_t strobe;
  logic      illegalHit, alignHit;

  qas_ctrl u_ctrl (
    .clk            (clk),
    .rst_n          (rst_n),
    .reqValid       (reqValid),
    .reqIsStore     (reqIsStore),
    .illegalHit     (illegalHit),
    .alignHit       (alignHit),
    .memAck         (memAck),
    .memErr         (memErr),
    .strobe         (strobe),
    .busy           (busy),
    .memReqValid    (memReqValid),
    .memReqWrite    (memReqWrite),
    .wbValid        (wbValid),
    .opDone         (opDone),
    .excValid       (excValid),
    .excVector      (excVector),
    .excSavedStatus (excSavedStatus)
  );

  qas_datapath #(
    .ADDR_W        (ADDR_W),
    .DATA_W        (DATA_W),
    .REG_W         (REG_W),
    .LE_PREF_FAULT (LE_PREF_FAULT)
  ) u_dp (
    .clk          (clk),
    .rst_n        (rst_n),
    .strobe       (strobe),
    .reqIsStore   (reqIsStore),
    .reqIsReserve (reqIsReserve),
    .reqPreferred (reqPreferred),
    .reqLittle    (reqLittle),
    .reqAddr      (reqAddr),
    .reqTgt       (reqTgt),
    .reqBase      (reqBase),
    .reqIndex     (reqIndex),
    .reqStLo      (reqStLo),
    .reqStHi      (reqStHi),
    .memRdData    (memRdData),
    .illegalHit   (illegalHit),
    .alignHit     (alignHit),
    .memReqAddr   (memReqAddr),
    .memReqWData  (memReqWData),
    .wbRegLo      (wbRegLo),
    .wbRegHi      (wbRegHi),
    .wbDataLo     (wbDataLo),
    .wbDataHi     (wbDataHi),
    .faultAddr    (excDataAddr)
  );

  AST_ADDR_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
    memReqValid && !memAck |=> $stable(memReqAddr)) else $error("address moved"); // R2
  AST_MEM_ONLY_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    memReqValid |-> busy) else $error("access while idle"); // R3
  AST_WB_EXC_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
    !(wbValid && excValid)) else $error("write-back with exception"); // R13
  AST_ILLEGAL_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
    excValid |-> (excSavedStatus[CAUSE_ILLEGAL_BIT] == (excVector == VEC_ILLEGAL)))
    else $error("illegal cause bit mismatch"); // R7
  AST_ALIGN_NO_ACCESS: assert property (@(posedge clk) disable iff (!rst_n)
    excValid && excVector == VEC_ALIGN |-> $past(!memReqValid)) else $error("access before align fault"); // R9

endmodule

// File: tb/quad_access_splitter_tb.sv
module qas_tb_mem #(
  parameter int unsigned ADDR_W = 32,
  parameter int unsigned DATA_W = 64
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reqValid,
  input  logic              reqWrite,
  input  logic [ADDR_W-1:0] reqAddr,
  input  logic [DATA_W-1:0] reqWData,
  output logic              ack,
  output logic              err,
  output logic [DATA_W-1:0] rdData
);
  int                ackDelay = 0;
  bit                errEn = 0;
  logic [ADDR_W-1:0] errAddr = '0;
  int                accessCount = 0;
  logic [ADDR_W-1:0] logAddr [4];
  logic [DATA_W-1:0] logData [4];
  bit                logWrite [4];
  int                waitCnt = 0;

  initial begin
    ack = 0; err = 0; rdData = '0;
  end

  always @(negedge clk) begin
    ack = 0; err = 0;
    if (!rst_n || !reqValid) waitCnt = 0;
    else if (waitCnt >= ackDelay) begin
      ack    = 1;
      err    = errEn && (reqAddr == errAddr);
      rdData = {8'h5A, reqAddr[23:0], 8'hA5, ~reqAddr[23:0]};
      if (accessCount < 4) begin
        logAddr[accessCount]  = reqAddr;
        logData[accessCount]  = reqWData;
        logWrite[accessCount] = reqWrite;
      end
      accessCount++;
      waitCnt = 0;
    end else waitCnt++;
  end
endmodule

module quad_access_splitter_tb;
  localparam int CLK_PERIOD = 10;
  localparam int AW = 32;
  localparam int DW = 64;
  localparam int RW = 5;
  localparam int WATCHDOG = 100000;

  logic clk = 0;
  logic rst_n = 0;
  always #(CLK_PERIOD/2) clk = ~clk;

  logic          reqValid = 0, reqIsStore = 0, reqIsReserve = 0, reqPreferred = 1, reqLittle = 0;
  logic [AW-1:0] reqAddr = '0;
  logic [RW-1:0] reqTgt = '0, reqBase = '0, reqIndex = '0;
  logic [DW-1:0] reqStLo = '0, reqStHi = '0;

  // outputs per instance: index 0 = u_dut (completes), 1 = u_dut_strict (faults)
  logic          busyV [2], mValid [2], mWrite [2], mAck [2], mErr [2];
  logic [AW-1:0] mAddr [2], eAddr [2];
  logic [DW-1:0] mWData [2], mRData [2], wLoD [2], wHiD [2];
  logic          wbV [2], doneV [2], excV [2];
  logic [RW-1:0] wLoR [2], wHiR [2];
  logic [11:0]   eVec [2];
  logic [31:0]   eStat [2];

  quad_access_splitter #(.ADDR_W(AW), .DATA_W(DW), .REG_W(RW), .LE_PREF_FAULT(1'b0)) u_dut (
    .clk(clk), .rst_n(rst_n), .reqValid(reqValid), .reqIsStore(reqIsStore),
    .reqIsReserve(reqIsReserve), .reqPreferred(reqPreferred), .reqLittle(reqLittle),
    .reqAddr(reqAddr), .reqTgt(reqTgt), .reqBase(reqBase), .reqIndex(reqIndex),
    .reqStLo(reqStLo), .reqStHi(reqStHi), .busy(busyV[0]), .memReqValid(mValid[0]),
    .memReqWrite(mWrite[0]), .memReqAddr(mAddr[0]), .memReqWData(mWData[0]),
    .memAck(mAck[0]), .memErr(mErr[0]), .memRdData(mRData[0]), .wbValid(wbV[0]),
    .wbRegLo(wLoR[0]), .wbDataLo(wLoD[0]), .wbRegHi(wHiR[0]), .wbDataHi(wHiD[0]),
    .opDone(doneV[0]), .excValid(excV[0]), .excVector(eVec[0]), .excDataAddr(eAddr[0]),
    .excSavedStatus(eStat[0]));

  quad_access_splitter #(.ADDR_W(AW), .DATA_W(DW), .REG_W(RW), .LE_PREF_FAULT(1'b1)) u_dut_strict (
    .clk(clk), .rst_n(rst_n), .reqValid(reqValid), .reqIsStore(reqIsStore),
    .reqIsReserve(reqIsReserve), .reqPreferred(reqPreferred), .reqLittle(reqLittle),
    .reqAddr(reqAddr), .reqTgt(reqTgt), .reqBase(reqBase), .reqIndex(reqIndex),
    .reqStLo(reqStLo), .reqStHi(reqStHi), .busy(busyV[1]), .memReqValid(mValid[1]),
    .memReqWrite(mWrite[1]), .memReqAddr(mAddr[1]), .memReqWData(mWData[1]),
    .memAck(mAck[1]), .memErr(mErr[1]), .memRdData(mRData[1]), .wbValid(wbV[1]),
    .wbRegLo(wLoR[1]), .wbDataLo(wLoD[1]), .wbRegHi(wHiR[1]), .wbDataHi(wHiD[1]),
    .opDone(doneV[1]), .excValid(excV[1]), .excVector(eVec[1]), .excDataAddr(eAddr[1]),
    .excSavedStatus(eStat[1]));

  qas_tb_mem #(.ADDR_W(AW), .DATA_W(DW)) u_memA (
    .clk(clk), .rst_n(rst_n), .reqValid(mValid[0]), .reqWrite(mWrite[0]), .reqAddr(mAddr[0]),
    .reqWData(mWData[0]), .ack(mAck[0]), .err(mErr[0]), .rdData(mRData[0]));
  qas_tb_mem #(.ADDR_W(AW), .DATA_W(DW)) u_memB (
    .clk(clk), .rst_n(rst_n), .reqValid(mValid[1]), .reqWrite(mWrite[1]), .reqAddr(mAddr[1]),
    .reqWData(mWData[1]), .ack(mAck[1]), .err(mErr[1]), .rdData(mRData[1]));

  int nChecks = 0;
  int nFail = 0;
  int cycles = 0;

  // captured results of the last operation
  bit            cWb [2], cExc [2], cSeen [2];
  logic [11:0]   cVec [2];
  logic [AW-1:0] cDAddr [2];
  logic [31:0]   cStat [2];
  logic [DW-1:0] cLoD [2], cHiD [2];
  logic [RW-1:0] cLoR [2], cHiR [2];
  bit            busyAfterAccept;

  function automatic logic [DW-1:0] pat(input logic [AW-1:0] a);
    return {8'h5A, a[23:0], 8'hA5, ~a[23:0]};
  endfunction

  task automatic chkEq(input string tag, input logic [63:0] act, input logic [63:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic summary();
    $display("  [TB] %0d tests run, %0d failed", nChecks, nFail);
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles == WATCHDOG) begin
      nChecks++; nFail++;
      $display("FAIL watchdog actual=%0d expected<%0d", cycles, WATCHDOG);
      summary();
      $finish;
    end
  end

  task automatic clearMem();
    u_memA.accessCount = 0; u_memB.accessCount = 0;
    u_memA.errEn = 0; u_memB.errEn = 0;
    u_memA.ackDelay = 0; u_memB.ackDelay = 0;
  endtask

  task automatic setReq(input bit st, input bit rsv, input bit pref, input bit le,
                        input logic [AW-1:0] a, input logic [RW-1:0] t,
                        input logic [RW-1:0] b, input logic [RW-1:0] x);
    reqIsStore = st; reqIsReserve = rsv; reqPreferred = pref; reqLittle = le;
    reqAddr = a; reqTgt = t; reqBase = b; reqIndex = x;
  endtask

  task automatic runOp(input bit intrude);
    int waitN;
    for (int i = 0; i < 2; i++) cSeen[i] = 0;
    @(negedge clk); reqValid = 1;
    @(negedge clk);
    busyAfterAccept = busyV[0];
    if (intrude) begin
      reqAddr = reqAddr + 32'h100;
      @(negedge clk); @(negedge clk);
    end
    reqValid = 0;
    waitN = 0;
    while (!(cSeen[0] && cSeen[1]) && waitN < 80) begin
      for (int i = 0; i < 2; i++) begin
        if (!cSeen[i] && doneV[i]) begin
          cSeen[i] = 1; cWb[i] = wbV[i]; cExc[i] = excV[i]; cVec[i] = eVec[i];
          cDAddr[i] = eAddr[i]; cStat[i] = eStat[i]; cLoD[i] = wLoD[i]; cHiD[i] = wHiD[i];
          cLoR[i] = wLoR[i]; cHiR[i] = wHiR[i];
        end
      end
      if (!(cSeen[0] && cSeen[1])) @(negedge clk);
      waitN++;
    end
    chkEq("op completion", {62'd0, cSeen[1], cSeen[0]}, 64'd3);
  endtask

  task automatic testReset();
    chkEq("R1 busy", busyV[0], 0);
    chkEq("R1 memReqValid", mValid[0], 0);
    chkEq("R1 wbValid", wbV[0], 0);
    chkEq("R1 excValid", excV[0], 0);
    chkEq("R1 opDone", doneV[0], 0);
  endtask

  task automatic testBeLoad();
    logic [AW-1:0] a = 32'h0000_1000;
    clearMem();
    setReq(0, 0, 1, 0, a, 5'd6, 5'd3, 5'd4);
    runOp(0);
    chkEq("R2 access count", u_memA.accessCount, 2);
    chkEq("R2 first addr", u_memA.logAddr[0], a);
    chkEq("R2 second addr", u_memA.logAddr[1], a + 8);
    chkEq("R4 wb valid", cWb[0], 1);
    chkEq("R4 even reg data", cLoD[0], pat(a));
    chkEq("R4 odd reg data", cHiD[0], pat(a + 8));
    chkEq("R14 even reg", cLoR[0], 6);
    chkEq("R14 odd reg", cHiR[0], 7);
    clearMem();
    setReq(0, 0, 1, 0, 32'h0000_2000, 5'd11, 5'd3, 5'd4);
    u_memA.ackDelay = 2;
    runOp(0);
    chkEq("R14 odd target even reg", cLoR[0], 10);
    chkEq("R14 odd target odd reg", cHiR[0], 11);
    chkEq("R2 delayed ack count", u_memA.accessCount, 2);
  endtask

  task automatic testLeLoad();
    logic [AW-1:0] a = 32'h0000_3040;
    clearMem();
    setReq(0, 0, 0, 1, a, 5'd8, 5'd1, 5'd2);
    runOp(0);
    chkEq("R5 wb valid", cWb[0], 1);
    chkEq("R5 even reg data", cLoD[0], pat(a + 8));
    chkEq("R5 odd reg data", cHiD[0], pat(a));
    chkEq("R5 first addr", u_memA.logAddr[0], a);
  endtask

  task automatic testStores();
    logic [AW-1:0] a = 32'h0000_4001;
    clearMem();
    reqStLo = 64'h1111_2222_3333_4444; reqStHi = 64'h5555_6666_7777_8888;
    setReq(1, 0, 1, 0, a, 5'd4, 5'd4, 5'd9);
    runOp(0);
    chkEq("R11 BE store no exception", cExc[0], 0);
    chkEq("R7 store src==base legal", u_memA.accessCount, 2);
    chkEq("R6 BE first data", u_memA.logData[0], reqStLo);
    chkEq("R6 BE second data", u_memA.logData[1], reqStHi);
    chkEq("R11 BE second addr", u_memA.logAddr[1], a + 8);
    chkEq("R6 write flag", u_memA.logWrite[0], 1);
    chkEq("R6 store no wb", cWb[0], 0);
    clearMem();
    setReq(1, 0, 0, 1, a, 5'd4, 5'd2, 5'd9);
    runOp(0);
    chkEq("R11 LE store no exception", cExc[0], 0);
    chkEq("R11 LE store strict no exception", cExc[1], 0);
    chkEq("R6 LE first data", u_memA.logData[0], reqStHi);
    chkEq("R6 LE second data", u_memA.logData[1], reqStLo);
    chkEq("R11 LE first addr", u_memA.logAddr[0], a);
  endtask

  task automatic testIllegal();
    clearMem();
    setReq(0, 0, 1, 0, 32'h0000_5000, 5'd6, 5'd6, 5'd2);
    runOp(0);
    chkEq("R7 vector", cVec[0], 12'h700);
    chkEq("R7 cause bit", cStat[0], 32'h0008_0000);
    chkEq("R7 no access", u_memA.accessCount, 0);
    chkEq("R7 no wb", cWb[0], 0);
    clearMem();
    setReq(0, 1, 1, 0, 32'h0000_5000, 5'd6, 5'd2, 5'd6);
    runOp(0);
    chkEq("R8 reserve tgt==index vector", cVec[0], 12'h700);
    chkEq("R8 reserve no access", u_memA.accessCount, 0);
    clearMem();
    setReq(0, 1, 1, 0, 32'h0000_5000, 5'd6, 5'd6, 5'd3);
    runOp(0);
    chkEq("R8 reserve tgt==base vector", cVec[0], 12'h700);
    clearMem();
    setReq(0, 0, 1, 0, 32'h0000_5000, 5'd6, 5'd2, 5'd6);
    runOp(0);
    chkEq("R8 plain tgt==index legal exc", cExc[0], 0);
    chkEq("R8 plain tgt==index wb", cWb[0], 1);
  endtask

  task automatic testAlign();
    logic [AW-1:0] a = 32'h0000_6008;
    clearMem();
    setReq(0, 0, 0, 1, a, 5'd10, 5'd1, 5'd2);
    runOp(0);
    chkEq("R9 vector", cVec[0], 12'h600);
    chkEq("R9 data addr", cDAddr[0], a);
    chkEq("R9 cause bit clear", cStat[0], 0);
    chkEq("R9 no access", u_memA.accessCount, 0);
    chkEq("R9 no wb", cWb[0], 0);
    clearMem();
    setReq(0, 0, 0, 0, a, 5'd10, 5'd1, 5'd2);
    runOp(0);
    chkEq("R10 BE non-preferred no exc", cExc[0], 0);
    chkEq("R10 BE non-preferred data", cLoD[0], pat(a));
    clearMem();
    setReq(0, 0, 1, 0, a, 5'd10, 5'd1, 5'd2);
    runOp(0);
    chkEq("R10 BE preferred no exc strict", cExc[1], 0);
    chkEq("R10 BE preferred data", cHiD[1], pat(a + 8));
    clearMem();
    setReq(0, 0, 1, 1, a, 5'd10, 5'd1, 5'd2);
    runOp(0);
    chkEq("R12 relaxed completes", cWb[0], 1);
    chkEq("R12 relaxed data", cLoD[0], pat(a + 8));
    chkEq("R12 strict vector", cVec[1], 12'h600);
    chkEq("R12 strict no access", u_memB.accessCount, 0);
  endtask

  task automatic testMemErr();
    logic [AW-1:0] a = 32'h0000_7000;
    clearMem();
    u_memA.errEn = 1; u_memA.errAddr = a + 8;
    setReq(0, 0, 1, 0, a, 5'd12, 5'd1, 5'd2);
    runOp(0);
    chkEq("R13 load vector", cVec[0], 12'h300);
    chkEq("R13 load data addr", cDAddr[0], a + 8);
    chkEq("R13 load no wb", cWb[0], 0);
    clearMem();
    u_memA.errEn = 1; u_memA.errAddr = a;
    setReq(1, 0, 1, 1, a, 5'd12, 5'd1, 5'd2);
    runOp(0);
    chkEq("R13 store vector", cVec[0], 12'h300);
    chkEq("R13 store data addr", cDAddr[0], a);
    chkEq("R13 store second half suppressed", u_memA.accessCount, 1);
  endtask

  task automatic testBusy();
    logic [AW-1:0] a = 32'h0000_8000;
    clearMem();
    u_memA.ackDelay = 3; u_memB.ackDelay = 3;
    setReq(0, 0, 1, 0, a, 5'd14, 5'd1, 5'd2);
    runOp(1);
    chkEq("R3 busy after accept", busyAfterAccept, 1);
    chkEq("R3 done with busy", busyV[0], 1);
    @(negedge clk);
    chkEq("R3 busy low after done", busyV[0], 0);
    repeat (6) @(negedge clk);
    chkEq("R3 intruding request ignored", u_memA.accessCount, 2);
    chkEq("R3 original address kept", u_memA.logAddr[0], a);
    chkEq("R3 still idle", busyV[0], 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    testReset();
    rst_n = 1;
    @(negedge clk);
    testBeLoad();
    testLeLoad();
    testStores();
    testIllegal();
    testAlign();
    testMemErr();
    testBusy();
    repeat (3) @(negedge clk);
    summary();
    $finish;
  end
endmodule